// File: doc/BRIEF.md
# Tagged Multi-Operation Custom Function Array

This block is a reconfigurable function unit next to a processor's register file. It holds several custom operations at the same time. Each operation sits in one slot, which is marked with the opcode it implements. The unit has a live copy of a few architectural registers, each with a ready flag. The logic rows of every slot evaluate those values all the time, so an operation starts computing as soon as a register is written back.

A custom opcode arrives on a one-cycle issue strobe. If a resident slot carries that opcode, the unit waits until every register the slot uses is ready. It then returns that slot's row output and raises a one-cycle result strobe. If no slot carries the opcode, the unit asks a backing configuration store for the operation. It waits for the answer, writes it into the least recently used slot, and then carries on as for a hit.

The unit holds the processor stalled from the cycle after issue through the result cycle. Only one custom operation is in flight at a time. The controller is a four-state machine:
- IDLE: waits for an issue. A hit goes to WAIT_OPS; a miss goes to RELOAD.
- RELOAD: asks for the configuration. It goes to WAIT_OPS in the cycle the store answers done.
- WAIT_OPS: waits until all used registers are ready, then goes to RESULT.
- RESULT: presents the result and goes back to IDLE.

Top module: `tagop_unit`

## Requirements
- R1: During reset and after reset, `stall`, `res_valid` and `rld_req` are low, and no slot is valid, so the first issue of any opcode is a miss.
- R2: On a hit whose used registers are all ready, `stall` is high in the first cycle after the issue edge. `res_valid` is high for exactly one cycle, the second cycle after the issue edge.
- R3: A configuration word has bits [3:0] as the register-use mask (bit i selects register i), bits [5:4] as the first-row function, bits [7:6] as the second-row function, and bits [15:8] as a constant K. The first-row functions over the selected registers are: 00 sum mod 256, 01 XOR, 10 AND (all ones when nothing is selected), 11 OR. The second row works on the first-row value: 00 passes it, 01 adds K, 10 XORs it with K, 11 rotates it left by one. `res_data` carries the second-row value.
- R4: If a used register is not ready, `res_valid` stays low and `stall` stays high. `res_valid` rises in the cycle after the first edge at which all used registers are ready, and the result uses the register values present at that edge.
- R5: The ready flags of registers outside the use mask have no effect on latency. An empty mask completes with hit latency.
- R6: On a miss, `rld_req` goes high in the cycle after issue with `rld_op` equal to the issued opcode. It holds until `rld_done`. `res_valid` follows two cycles after the edge that samples `rld_done`, when the operands are ready.
- R7: A miss fills an invalid slot if one exists. Otherwise it replaces the least recently used slot. Both a hit and a fill count as a use.
- R8: An issue strobe while `stall` is high is ignored.
- R9: `stall` is high in the result cycle and low in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| snoop_data | input | NREG*DW | Live register copies, register i at bits [i*DW +: DW] |
| snoop_rdy | input | NREG | Per-register ready flag; low while a write is pending |
| iss_valid | input | 1 | Custom opcode issue strobe |
| iss_op | input | OPW | Issued custom opcode |
| stall | output | 1 | Processor stall |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | DW | Result value |
| rld_req | output | 1 | Configuration reload request |
| rld_op | output | OPW | Opcode whose configuration is requested |
| rld_done | input | 1 | Reload answer strobe |
| rld_cfg | input | NREG+4+DW | Configuration word delivered with `rld_done` |

## Verification
The hardest case to reach from the ports is the replacement order. A slot is evicted only when all four slots hold different opcodes, and which slot goes depends on the whole recent history of hits and fills. The stimulus first runs a fixed hit/miss script that makes a specific slot the oldest. It then sweeps all sixteen opcodes three times while a recency list in the bench predicts every miss. A miss shows up as a request on the reload port.

Late operands are produced by holding one used ready flag low across several cycles and then rewriting that register as the flag rises. Ignored issues are produced by strobing a non-resident opcode during a stall and then showing that it still misses afterwards.

// File: rtl/tagop_pkg.sv
package tagop_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_RELOAD   = 2'd1,
        ST_WAIT_OPS = 2'd2,
        ST_RESULT   = 2'd3
    } tagop_state_e;

    localparam logic [1:0] F0_SUM = 2'b00;
    localparam logic [1:0] F0_XOR = 2'b01;
    localparam logic [1:0] F0_AND = 2'b10;
    localparam logic [1:0] F0_OR  = 2'b11;

    localparam logic [1:0] F1_PASS = 2'b00;
    localparam logic [1:0] F1_ADDK = 2'b01;
    localparam logic [1:0] F1_XORK = 2'b10;
    localparam logic [1:0] F1_ROTL = 2'b11;

endpackage

// File: rtl/tagop_rows.sv
module tagop_rows
    import tagop_pkg::*;
#(
    parameter int NREG = 4,
    parameter int DW   = 8,
    localparam int CFGW = NREG + 4 + DW
) (
    input  logic [NREG*DW-1:0] regs,
    input  logic [CFGW-1:0]    cfg,
    output logic [DW-1:0]      row_out
);

    logic [NREG-1:0] use_mask;
    logic [1:0]      fn_a;
    logic [1:0]      fn_b;
    logic [DW-1:0]   kconst;
    logic [DW-1:0]   row_a;

    assign use_mask = cfg[NREG-1:0];
    assign fn_a     = cfg[NREG+1:NREG];
    assign fn_b     = cfg[NREG+3:NREG+2];
    assign kconst   = cfg[CFGW-1:NREG+4];

    // first row: reduction over the selected live registers
    always_comb begin
        row_a = (fn_a == F0_AND) ? {DW{1'b1}} : {DW{1'b0}};
        for (int i = 0; i < NREG; i++) begin
            if (use_mask[i]) begin
                unique case (fn_a)
                    F0_SUM: row_a = row_a + regs[i*DW +: DW];
                    F0_XOR: row_a = row_a ^ regs[i*DW +: DW];
                    F0_AND: row_a = row_a & regs[i*DW +: DW];
                    F0_OR:  row_a = row_a | regs[i*DW +: DW];
                endcase
            end
        end
    end

    // second row: works on the intermediate value of the first row
    always_comb begin
        unique case (fn_b)
            F1_PASS: row_out = row_a;
            F1_ADDK: row_out = row_a + kconst;
            F1_XORK: row_out = row_a ^ kconst;
            F1_ROTL: row_out = {row_a[DW-2:0], row_a[DW-1]};
        endcase
    end

endmodule

// File: rtl/tagop_tags.sv
module tagop_tags #(
    parameter int NSLOT = 4,
    parameter int OPW   = 4,
    parameter int CFGW  = 16,
    localparam int IW   = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [OPW-1:0]        look_op,
    output logic                  hit,
    output logic [IW-1:0]         hit_idx,
    output logic [IW-1:0]         victim_idx,
    input  logic                  touch_en,
    input  logic [IW-1:0]         touch_idx,
    input  logic                  fill_en,
    input  logic [IW-1:0]         fill_idx,
    input  logic [OPW-1:0]        fill_tag,
    input  logic [CFGW-1:0]       fill_cfg,
    output logic [NSLOT*CFGW-1:0] slot_cfg
);

    logic [NSLOT-1:0] vld_q;
    logic [OPW-1:0]   tag_q [NSLOT];
    logic [CFGW-1:0]  cfg_q [NSLOT];
    logic [IW-1:0]    age_q [NSLOT];
    logic             any_free;

    // tag match, lowest index wins
    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int i = NSLOT - 1; i >= 0; i--) begin
            if (vld_q[i] && (tag_q[i] == look_op)) begin
                hit     = 1'b1;
                hit_idx = IW'(i);
            end
        end
    end

    // victim: lowest free slot, else the oldest one
    always_comb begin
        any_free   = 1'b0;
        victim_idx = '0;
        for (int i = NSLOT - 1; i >= 0; i--) begin
            if (!vld_q[i]) begin
                any_free   = 1'b1;
                victim_idx = IW'(i);
            end
        end
        if (!any_free) begin
            for (int i = 0; i < NSLOT; i++) begin
                if (age_q[i] == IW'(NSLOT - 1)) victim_idx = IW'(i);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            for (int i = 0; i < NSLOT; i++) begin
                tag_q[i] <= '0;
                cfg_q[i] <= '0;
                age_q[i] <= IW'(i);
            end
        end else begin
            if (fill_en) begin
                vld_q[fill_idx] <= 1'b1;
                tag_q[fill_idx] <= fill_tag;
                cfg_q[fill_idx] <= fill_cfg;
            end
            if (touch_en) begin
                for (int j = 0; j < NSLOT; j++) begin
                    if (IW'(j) == touch_idx)             age_q[j] <= '0;
                    else if (age_q[j] < age_q[touch_idx]) age_q[j] <= age_q[j] + 1'b1;
                end
            end
        end
    end

    for (genvar s = 0; s < NSLOT; s++) begin : g_cfg_out
        assign slot_cfg[s*CFGW +: CFGW] = cfg_q[s];
    end

endmodule

// File: rtl/tagop_fsm.sv
module tagop_fsm
    import tagop_pkg::*;
#(
    parameter int NSLOT = 4,
    parameter int OPW   = 4,
    localparam int IW   = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           iss_valid,
    input  logic [OPW-1:0] iss_op,
    input  logic           hit,
    input  logic [IW-1:0]  hit_idx,
    input  logic [IW-1:0]  victim_idx,
    input  logic           rld_done,
    input  logic           all_ready,
    output logic           stall,
    output logic           rld_req,
    output logic           res_valid,
    output logic           capture,
    output logic           touch_en,
    output logic [IW-1:0]  touch_idx,
    output logic           fill_en,
    output logic [IW-1:0]  cur_slot,
    output logic [OPW-1:0] cur_op
);

    tagop_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (iss_valid) state_d = hit ? ST_WAIT_OPS : ST_RELOAD;
            ST_RELOAD:   if (rld_done)  state_d = ST_WAIT_OPS;
            ST_WAIT_OPS: if (all_ready) state_d = ST_RESULT;
            ST_RESULT:                  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            cur_slot <= '0;
            cur_op   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && iss_valid) begin
                cur_op   <= iss_op;
                cur_slot <= hit ? hit_idx : victim_idx;
            end
        end
    end

    always_comb begin
        stall     = (state_q != ST_IDLE);
        rld_req   = (state_q == ST_RELOAD);
        res_valid = (state_q == ST_RESULT);
        capture   = (state_q == ST_WAIT_OPS) && all_ready;
        fill_en   = (state_q == ST_RELOAD) && rld_done;
        touch_en  = fill_en || ((state_q == ST_IDLE) && iss_valid && hit);
        touch_idx = fill_en ? cur_slot : hit_idx;
    end

endmodule

// File: rtl/tagop_unit.sv
module tagop_unit #(
    parameter int NREG  = 4,
    parameter int DW    = 8,
    parameter int OPW   = 4,
    parameter int NSLOT = 4,
    localparam int CFGW = NREG + 4 + DW,
    localparam int IW   = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NREG*DW-1:0] snoop_data,
    input  logic [NREG-1:0]    snoop_rdy,
    input  logic               iss_valid,
    input  logic [OPW-1:0]     iss_op,
    output logic               stall,
    output logic               res_valid,
    output logic [DW-1:0]      res_data,
    output logic               rld_req,
    output logic [OPW-1:0]     rld_op,
    input  logic               rld_done,
    input  logic [CFGW-1:0]    rld_cfg
);

    logic [NSLOT*CFGW-1:0] slot_cfg;
    logic [NSLOT*DW-1:0]   row_out;
    logic                  hit;
    logic [IW-1:0]         hit_idx;
    logic [IW-1:0]         victim_idx;
    logic                  touch_en;
    logic [IW-1:0]         touch_idx;
    logic                  fill_en;
    logic                  capture;
    logic [IW-1:0]         cur_slot;
    logic [OPW-1:0]        cur_op;
    logic [CFGW-1:0]       cur_cfg;
    logic [NREG-1:0]       cur_mask;
    logic                  all_ready;
    logic [DW-1:0]         res_q;

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        tagop_rows #(.NREG(NREG), .DW(DW)) u_rows (
            .regs    (snoop_data),
            .cfg     (slot_cfg[s*CFGW +: CFGW]),
            .row_out (row_out[s*DW +: DW])
        );
    end

    tagop_tags #(.NSLOT(NSLOT), .OPW(OPW), .CFGW(CFGW)) u_tags (
        .clk        (clk),
        .rst_n      (rst_n),
        .look_op    (iss_op),
        .hit        (hit),
        .hit_idx    (hit_idx),
        .victim_idx (victim_idx),
        .touch_en   (touch_en),
        .touch_idx  (touch_idx),
        .fill_en    (fill_en),
        .fill_idx   (cur_slot),
        .fill_tag   (cur_op),
        .fill_cfg   (rld_cfg),
        .slot_cfg   (slot_cfg)
    );

    tagop_fsm #(.NSLOT(NSLOT), .OPW(OPW)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .iss_valid  (iss_valid),
        .iss_op     (iss_op),
        .hit        (hit),
        .hit_idx    (hit_idx),
        .victim_idx (victim_idx),
        .rld_done   (rld_done),
        .all_ready  (all_ready),
        .stall      (stall),
        .rld_req    (rld_req),
        .res_valid  (res_valid),
        .capture    (capture),
        .touch_en   (touch_en),
        .touch_idx  (touch_idx),
        .fill_en    (fill_en),
        .cur_slot   (cur_slot),
        .cur_op     (cur_op)
    );

    assign cur_cfg   = slot_cfg[int'(cur_slot)*CFGW +: CFGW];
    assign cur_mask  = cur_cfg[NREG-1:0];
    assign all_ready = ((snoop_rdy & cur_mask) == cur_mask);

    always_ff @(posedge clk) begin
        if (!rst_n)       res_q <= '0;
        else if (capture) res_q <= row_out[int'(cur_slot)*DW +: DW];
    end

    assign res_data = res_q;
    assign rld_op   = cur_op;

endmodule

// File: rtl/tagop_unit_chk.sv
module tagop_unit_chk #(
    parameter int NREG = 4,
    parameter int OPW  = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            stall,
    input logic            res_valid,
    input logic            rld_req,
    input logic            rld_done,
    input logic [OPW-1:0]  rld_op,
    input logic [NREG-1:0] snoop_rdy,
    input logic [NREG-1:0] cur_mask
);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !stall |-> (!res_valid && !rld_req));

    p_res_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    p_ready_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past((snoop_rdy & cur_mask) == cur_mask));

    p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rld_req && !rld_done) |=> (rld_req && $stable(rld_op)));

    p_req_stalls_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rld_req |-> stall);

    p_busy_lock_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> $stable(rld_op));

    p_res_in_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> stall);

    p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !stall);

endmodule

bind tagop_unit tagop_unit_chk #(.NREG(NREG), .OPW(OPW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .stall     (stall),
    .res_valid (res_valid),
    .rld_req   (rld_req),
    .rld_done  (rld_done),
    .rld_op    (rld_op),
    .snoop_rdy (snoop_rdy),
    .cur_mask  (cur_mask)
);

// File: tb/tagop_unit_bench.sv
module tagop_unit_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NREG       = 4;
    localparam int DW         = 8;
    localparam int OPW        = 4;
    localparam int NSLOT      = 4;
    localparam int CFGW       = NREG + 4 + DW;
    localparam int RLD_DELAY  = 3;

    logic               clk;
    logic               rst_n;
    logic [NREG*DW-1:0] snoop_data;
    logic [NREG-1:0]    snoop_rdy;
    logic               iss_valid;
    logic [OPW-1:0]     iss_op;
    logic               stall;
    logic               res_valid;
    logic [DW-1:0]      res_data;
    logic               rld_req;
    logic [OPW-1:0]     rld_op;
    logic               rld_done;
    logic [CFGW-1:0]    rld_cfg;
    logic [DW-1:0]      regv [NREG];

    int total;
    int bad;
    int mru [NSLOT];
    int mru_n;

    tagop_unit #(.NREG(NREG), .DW(DW), .OPW(OPW), .NSLOT(NSLOT)) u_tagop_unit (
        .clk        (clk),
        .rst_n      (rst_n),
        .snoop_data (snoop_data),
        .snoop_rdy  (snoop_rdy),
        .iss_valid  (iss_valid),
        .iss_op     (iss_op),
        .stall      (stall),
        .res_valid  (res_valid),
        .res_data   (res_data),
        .rld_req    (rld_req),
        .rld_op     (rld_op),
        .rld_done   (rld_done),
        .rld_cfg    (rld_cfg)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    always_comb begin
        for (int i = 0; i < NREG; i++) snoop_data[i*DW +: DW] = regv[i];
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // configuration store contents, following the R3 word layout
    function automatic logic [CFGW-1:0] cfg_of(input int op);
        int msk, fa, fb, k;
        msk = (op * 7 + 1) & 15;
        fa  = op & 3;
        fb  = (op >> 2) & 3;
        k   = (op * 37 + 11) & 255;
        return CFGW'((k << 8) | (fb << 6) | (fa << 4) | msk);
    endfunction

    function automatic int exp_res(input int op);
        logic [CFGW-1:0] c;
        int acc, fa, fb, k;
        c   = cfg_of(op);
        fa  = int'(c[5:4]);
        fb  = int'(c[7:6]);
        k   = int'(c[15:8]);
        acc = (fa == 2) ? 255 : 0;
        for (int i = 0; i < NREG; i++) begin
            if (c[i]) begin
                case (fa)
                    0: acc = (acc + int'(regv[i])) & 255;
                    1: acc = acc ^ int'(regv[i]);
                    2: acc = acc & int'(regv[i]);
                    default: acc = acc | int'(regv[i]);
                endcase
            end
        end
        case (fb)
            0: return acc;
            1: return (acc + k) & 255;
            2: return acc ^ k;
            default: return ((acc << 1) | (acc >> 7)) & 255;
        endcase
    endfunction

    // recency list predicted from R7: mru[0] is the newest
    task automatic model_access(input int op, output bit miss);
        int pos;
        pos = -1;
        for (int i = 0; i < mru_n; i++) if (mru[i] == op) pos = i;
        miss = (pos < 0);
        if (miss) begin
            if (mru_n < NSLOT) mru_n++;
            pos = mru_n - 1;
        end
        for (int i = pos; i > 0; i--) mru[i] = mru[i-1];
        mru[0] = op;
    endtask

    // reload responder: answers a request after RLD_DELAY cycles
    initial begin
        int cnt;
        cnt      = 0;
        rld_done = 1'b0;
        rld_cfg  = '0;
        forever begin
            @(negedge clk);
            if (rld_req && !rld_done) begin
                cnt++;
                if (cnt >= RLD_DELAY) begin
                    rld_done = 1'b1;
                    rld_cfg  = cfg_of(int'(rld_op));
                    cnt      = 0;
                end
            end else begin
                rld_done = 1'b0;
                cnt      = 0;
            end
        end
    end

    task automatic do_op(input int op, input bit interfere, input int other,
                         output bit seen_req);
        bit exp_miss, got, op_bad;
        int lat, exp_lat, data, expv;
        model_access(op, exp_miss);
        exp_lat  = exp_miss ? RLD_DELAY + 2 : 2;
        expv     = exp_res(op);
        seen_req = 1'b0;
        got      = 1'b0;
        op_bad   = 1'b0;
        lat      = 0;
        data     = 0;
        @(negedge clk);
        iss_valid = 1'b1;
        iss_op    = OPW'(op);
        for (int c = 1; c <= 40 && !got; c++) begin
            @(negedge clk);
            if (c == 1) chk(stall == 1'b1, "R2", "stall after issue", int'(stall), 1);
            if (rld_req) begin
                seen_req = 1'b1;
                if (int'(rld_op) != op) op_bad = 1'b1;
            end
            if (res_valid) begin
                got  = 1'b1;
                lat  = c;
                data = int'(res_data);
            end
            if (c == 1 && interfere) begin
                iss_valid = 1'b1;
                iss_op    = OPW'(other);
            end else begin
                iss_valid = 1'b0;
            end
        end
        iss_valid = 1'b0;
        chk(seen_req == exp_miss, "R7", "miss seen", int'(seen_req), int'(exp_miss));
        chk(!op_bad, "R6", "reload opcode", int'(op_bad), 0);
        chk(lat == exp_lat, exp_miss ? "R6" : "R2", "latency", lat, exp_lat);
        chk(data == expv, "R3", "result", data, expv);
        @(negedge clk);
        chk(stall == 1'b0, "R9", "stall released", int'(stall), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        bit sr;
        int expv;
        total     = 0;
        bad       = 0;
        mru_n     = 0;
        rst_n     = 1'b0;
        iss_valid = 1'b0;
        iss_op    = '0;
        snoop_rdy = '1;
        for (int i = 0; i < NREG; i++) regv[i] = DW'(i * 40 + 3);

        repeat (3) @(negedge clk);
        chk(!stall && !res_valid && !rld_req, "R1", "outputs in reset",
            int'({stall, res_valid, rld_req}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!stall && !res_valid && !rld_req, "R1", "outputs after reset",
            int'({stall, res_valid, rld_req}), 0);

        // R1 first issues miss; R7 scripted recency pattern
        foreach (regv[i]) regv[i] = DW'(i * 61 + 17);
        do_op(1, 0, 0, sr);
        chk(sr == 1'b1, "R1", "first issue misses", int'(sr), 1);
        do_op(2, 0, 0, sr); do_op(3, 0, 0, sr); do_op(4, 0, 0, sr);
        do_op(1, 0, 0, sr); do_op(2, 0, 0, sr); do_op(3, 0, 0, sr); do_op(4, 0, 0, sr);
        do_op(1, 0, 0, sr);
        do_op(5, 0, 0, sr);
        do_op(3, 0, 0, sr); do_op(4, 0, 0, sr); do_op(1, 0, 0, sr); do_op(5, 0, 0, sr);
        do_op(2, 0, 0, sr);
        do_op(3, 0, 0, sr);

        // sweep all opcodes under several register patterns
        for (int pass = 0; pass < 3; pass++) begin
            for (int op = 0; op < 16; op++) begin
                for (int i = 0; i < NREG; i++) regv[i] = DW'(op * 29 + pass * 53 + i * 17 + 5);
                do_op(op, 0, 0, sr);
            end
        end

        // R8: an issue during the stall is dropped, so op 9 still misses afterwards
        do_op(15, 1, 9, sr);
        do_op(9, 0, 0, sr);
        chk(sr == 1'b1, "R8", "ignored issue left no slot", int'(sr), 1);

        // R5: empty use mask (op 9) with every ready flag low
        snoop_rdy = '0;
        do_op(9, 0, 0, sr);
        // R5: op 14 uses registers 0 and 1; 2 and 3 not ready
        snoop_rdy = 4'b0011;
        do_op(14, 0, 0, sr);
        snoop_rdy = '1;

        // R4: late operand on register 1 for op 14
        model_access(14, sr);
        @(negedge clk);
        snoop_rdy[1] = 1'b0;
        iss_valid    = 1'b1;
        iss_op       = OPW'(14);
        for (int c = 1; c <= 4; c++) begin
            @(negedge clk);
            iss_valid = 1'b0;
            chk(!res_valid && stall, "R4", "held while operand pending",
                int'({res_valid, stall}), 1);
        end
        regv[1]      = 8'hA5;
        snoop_rdy[1] = 1'b1;
        expv         = exp_res(14);
        @(negedge clk);
        chk(res_valid == 1'b1, "R4", "result after operand ready", int'(res_valid), 1);
        chk(int'(res_data) == expv, "R4", "result uses late value", int'(res_data), expv);
        @(negedge clk);
        chk(stall == 1'b0, "R9", "stall released after late op", int'(stall), 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule